// File: doc/BRIEF.md
# Multifunction Pin Block with External Wake Inputs

This block sits between a small register port and a group of package pins. Six output pins each carry either a software-driven level or an alternate function. One of those alternate functions is built in: a write-protect line that drops low on the first access to a selected ROM page. The other alternate functions arrive as plain input signals. Five input pins are synchronised and can be read as general-purpose inputs. Two of them can also serve as external event inputs.

Each event input is set on its own to level or edge triggering. A triggered event input can raise a system-management interrupt request. The first one can also ask for a reduced CPU clock, and the second one can ask for the clock to stop. A clock request lasts as long as its source stays active. Software reaches every setting through one write strobe, a three-bit address and a six-bit data path. Reads come back combinationally.

Top module: `mfio_pins`

## Requirements
- R1: After reset, every output pin is high. The output-select register (address 0) reads 0x3B, the output-level register (address 1) reads 0x3F, and the event-select (2), trigger (3), enable (4) and pending (5) registers read 0.
- R2: Pin i drives bit i of the output-level register while bit i of the output-select register is 1. While that bit is 0, the pin drives its alternate signal. Alternate bus bit k serves pin k for k < 2 and pin k+1 otherwise.
- R3: The alternate function of pin 2 is write-protect. It is high after reset and goes low in the cycle after an access whose page equals 0x0F. It stays low until the output-select register is written. An access in the same cycle as such a write takes priority.
- R4: The input register (address 6) returns the five input pin levels as they were sampled two clock edges earlier. Bits 5 and above read 0.
- R5: Bit e of the event-select register (e = 0, 1) turns input pin e into an event input. While that bit is 0, the pin raises no interrupt and no clock request.
- R6: In level mode (trigger bit e = 0), an event input is active while its synchronised level is low. This shows two edges after the pin changes.
- R7: In edge mode (trigger bit e = 1), a high-to-low change of the synchronised level sets pending bit e (address 5) at the third edge after the pin falls. The bit stays set until software writes 1 to it. A new falling edge in the same cycle wins over the clear. While in edge mode, the event is active while its pending bit is set.
- R8: `smi_req` is high when event 0 is active with enable bit 0 set, or when event 1 is active with enable bit 2 set.
- R9: `clk_slow_req` equals active event 0 gated by enable bit 1. `clk_stop_req` equals active event 1 gated by enable bit 3. Either request drops, so the clock resumes, once its event is no longer active.
- R10: Writes take effect at the clock edge. Reads are combinational. Writes to addresses 5 (other than clearing), 6 and 7 change nothing, and addresses 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for `reg_addr` |
| alt_out | input | 5 | Alternate-function levels for the pins other than pin 2 |
| rom_acc | input | 1 | ROM access strobe |
| rom_page | input | 8 | Upper address byte of the ROM access |
| in_pins | input | 5 | Input pin levels (asynchronous) |
| out_pins | output | 6 | Driven output pin levels |
| smi_req | output | 1 | Interrupt request |
| clk_slow_req | output | 1 | Request for reduced CPU clock |
| clk_stop_req | output | 1 | Request to stop the CPU clock |

## Verification
Output pins and read data follow register state one edge after a write and follow the alternate signals combinationally. The write-protect level falls one edge after a matching access. Level-mode requests and the input register trail a pin change by two edges, while edge-mode pending bits trail it by three. The bench keeps a behavioural model that is stepped at each rising edge and compares every output at the falling edge. Directed checks apply a stimulus just after a rising edge, count out exactly those two or three edges, and then sample.

// File: rtl/mfio_pkg.sv
package mfio_pkg;

    // Number of event-capable inputs (index 0 drives slow, index 1 drives stop)
    localparam int N_EXT   = 2;
    localparam int RADDR_W = 3;

    typedef enum logic [RADDR_W-1:0] {
        RA_OUTSEL = 3'd0,
        RA_OUTVAL = 3'd1,
        RA_EVSEL  = 3'd2,
        RA_TRIG   = 3'd3,
        RA_EVEN   = 3'd4,
        RA_PEND   = 3'd5,
        RA_INLVL  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [N_EXT-1:0] sel;
        logic [N_EXT-1:0] edge_mode;
        logic [N_EXT-1:0] smi_en;
        logic [N_EXT-1:0] act_en;
    } ext_cfg_t;

    function automatic logic wr_hit(input logic wr, input logic [RADDR_W-1:0] addr,
                                    input reg_addr_e target);
        return wr && (reg_addr_e'(addr) == target);
    endfunction

endpackage

// File: rtl/mfio_regfile.sv
module mfio_regfile
    import mfio_pkg::*;
#(
    parameter int              N_OUT      = 6,
    parameter int              N_IN       = 5,
    parameter logic [N_OUT-1:0] RST_OUTSEL = 6'b111011
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [RADDR_W-1:0]  addr,
    input  logic [N_OUT-1:0]    wdata,
    output logic [N_OUT-1:0]    rdata,
    input  logic [N_EXT-1:0]    pend,
    input  logic [N_IN-1:0]     in_lvl,
    output logic [N_OUT-1:0]    outsel,
    output logic [N_OUT-1:0]    outval,
    output ext_cfg_t            cfg,
    output logic [N_EXT-1:0]    pend_clr,
    output logic                outsel_wr
);
    localparam int EN_W = 2 * N_EXT;

    logic [N_EXT-1:0] evsel_q, trig_q;
    logic [EN_W-1:0]  even_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outsel  <= RST_OUTSEL;
            outval  <= '1;
            evsel_q <= '0;
            trig_q  <= '0;
            even_q  <= '0;
        end else begin
            if (wr_hit(wr, addr, RA_OUTSEL)) outsel  <= wdata;
            if (wr_hit(wr, addr, RA_OUTVAL)) outval  <= wdata;
            if (wr_hit(wr, addr, RA_EVSEL))  evsel_q <= wdata[N_EXT-1:0];
            if (wr_hit(wr, addr, RA_TRIG))   trig_q  <= wdata[N_EXT-1:0];
            if (wr_hit(wr, addr, RA_EVEN))   even_q  <= wdata[EN_W-1:0];
        end
    end

    // Enable register: bit 2e = interrupt enable, bit 2e+1 = clock action enable
    for (genvar e = 0; e < N_EXT; e++) begin : g_cfg
        assign cfg.smi_en[e] = even_q[2*e];
        assign cfg.act_en[e] = even_q[2*e+1];
    end
    assign cfg.sel       = evsel_q;
    assign cfg.edge_mode = trig_q;

    assign pend_clr  = wr_hit(wr, addr, RA_PEND) ? wdata[N_EXT-1:0] : '0;
    assign outsel_wr = wr_hit(wr, addr, RA_OUTSEL);

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_OUTSEL: rdata = outsel;
            RA_OUTVAL: rdata = outval;
            RA_EVSEL:  rdata[N_EXT-1:0] = evsel_q;
            RA_TRIG:   rdata[N_EXT-1:0] = trig_q;
            RA_EVEN:   rdata[EN_W-1:0]  = even_q;
            RA_PEND:   rdata[N_EXT-1:0] = pend;
            RA_INLVL:  rdata[N_IN-1:0]  = in_lvl;
            default:   rdata = '0;
        endcase
    end

    // R10
    outval_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit(wr, addr, RA_OUTVAL) |=> $stable(outval));

endmodule

// File: rtl/mfio_wprot.sv
module mfio_wprot #(
    parameter int                PAGE_W  = 8,
    parameter logic [PAGE_W-1:0] WP_PAGE = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rom_acc,
    input  logic [PAGE_W-1:0] rom_page,
    input  logic              rearm,
    output logic              wp_lvl
);
    logic hit;
    assign hit = rom_acc && (rom_page == WP_PAGE);

    always_ff @(posedge clk) begin
        if (rst)        wp_lvl <= 1'b1;
        else if (hit)   wp_lvl <= 1'b0;
        else if (rearm) wp_lvl <= 1'b1;
    end

    // R3
    wp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rom_acc && rom_page == WP_PAGE) |=> !wp_lvl);

    // R3
    wp_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!wp_lvl && !rearm) |=> !wp_lvl);

endmodule

// File: rtl/mfio_insync.sv
module mfio_insync
    import mfio_pkg::*;
#(
    parameter int N_IN = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  pins,
    output logic [N_IN-1:0]  sync,
    output logic [N_EXT-1:0] prev
);
    logic [N_IN-1:0] stage1;

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b1;
                sync[i]   <= 1'b1;
            end else begin
                stage1[i] <= pins[i];
                sync[i]   <= stage1[i];
            end
        end
    end

    // Delayed copy for falling-edge detection on event-capable inputs
    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= sync[N_EXT-1:0];
    end

endmodule

// File: rtl/mfio_ext.sv
module mfio_ext
    import mfio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ext_cfg_t         cfg,
    input  logic [N_EXT-1:0] sync,
    input  logic [N_EXT-1:0] prev,
    input  logic [N_EXT-1:0] pend_clr,
    output logic [N_EXT-1:0] pend,
    output logic             smi_req,
    output logic             clk_slow_req,
    output logic             clk_stop_req
);
    logic [N_EXT-1:0] req;

    for (genvar e = 0; e < N_EXT; e++) begin : g_ev
        logic fall, set_p;
        assign fall  = prev[e] && !sync[e];
        assign set_p = cfg.sel[e] && cfg.edge_mode[e] && fall;

        always_ff @(posedge clk) begin
            if (rst) pend[e] <= 1'b0;
            else     pend[e] <= set_p || (pend[e] && !pend_clr[e]);
        end

        assign req[e] = cfg.sel[e] && (cfg.edge_mode[e] ? pend[e] : !sync[e]);

        // R7
        pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (pend[e] && !pend_clr[e]) |=> pend[e]);

        // R7
        pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
            (!pend[e] && !(cfg.edge_mode[e] && cfg.sel[e])) |=> !pend[e]);
    end

    assign smi_req      = |(req & cfg.smi_en);
    assign clk_slow_req = req[0] && cfg.act_en[0];
    assign clk_stop_req = req[1] && cfg.act_en[1];

    // R5
    unsel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.sel == '0) |-> !(smi_req || clk_slow_req || clk_stop_req));

    // R6
    level_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.sel[0] && !cfg.edge_mode[0] && !sync[0] && cfg.act_en[0]) |-> clk_slow_req);

endmodule

// File: rtl/mfio_pins.sv
module mfio_pins
    import mfio_pkg::*;
#(
    parameter int                 N_OUT      = 6,
    parameter int                 N_IN       = 5,
    parameter int                 WP_IDX     = 2,
    parameter int                 PAGE_W     = 8,
    parameter logic [PAGE_W-1:0]  WP_PAGE    = 8'h0F,
    parameter logic [N_OUT-1:0]   RST_OUTSEL = 6'b111011
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [N_OUT-1:0]   reg_wdata,
    output logic [N_OUT-1:0]   reg_rdata,
    input  logic [N_OUT-2:0]   alt_out,
    input  logic               rom_acc,
    input  logic [PAGE_W-1:0]  rom_page,
    input  logic [N_IN-1:0]    in_pins,
    output logic [N_OUT-1:0]   out_pins,
    output logic               smi_req,
    output logic               clk_slow_req,
    output logic               clk_stop_req
);
    logic [N_OUT-1:0] outsel, outval, alt_lvl;
    logic [N_IN-1:0]  in_sync;
    logic [N_EXT-1:0] prev, pend, pend_clr;
    ext_cfg_t         cfg;
    logic             outsel_wr, wp_lvl;

    mfio_regfile #(.N_OUT(N_OUT), .N_IN(N_IN), .RST_OUTSEL(RST_OUTSEL)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .pend(pend), .in_lvl(in_sync), .outsel(outsel),
        .outval(outval), .cfg(cfg), .pend_clr(pend_clr), .outsel_wr(outsel_wr)
    );

    mfio_wprot #(.PAGE_W(PAGE_W), .WP_PAGE(WP_PAGE)) u_wp (
        .clk(clk), .rst(rst), .rom_acc(rom_acc), .rom_page(rom_page),
        .rearm(outsel_wr), .wp_lvl(wp_lvl)
    );

    mfio_insync #(.N_IN(N_IN)) u_sync (
        .clk(clk), .rst(rst), .pins(in_pins), .sync(in_sync), .prev(prev)
    );

    mfio_ext u_ext (
        .clk(clk), .rst(rst), .cfg(cfg), .sync(in_sync[N_EXT-1:0]), .prev(prev),
        .pend_clr(pend_clr), .pend(pend), .smi_req(smi_req),
        .clk_slow_req(clk_slow_req), .clk_stop_req(clk_stop_req)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_alt
        if (i == WP_IDX) begin : g_wp
            assign alt_lvl[i] = wp_lvl;
        end else if (i < WP_IDX) begin : g_lo
            assign alt_lvl[i] = alt_out[i];
        end else begin : g_hi
            assign alt_lvl[i] = alt_out[i-1];
        end
    end

    assign out_pins = (outsel & outval) | (~outsel & alt_lvl);

    // R2
    gpo_drive_chk: assert property (@(posedge clk) disable iff (rst)
        outsel[0] |-> (out_pins[0] == outval[0]));

endmodule

// File: tb/test_mfio_pins.sv
module test_mfio_pins;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [5:0] reg_wdata = 6'd0;
    logic [4:0] alt_out = 5'd0;
    logic       rom_acc = 1'b0;
    logic [7:0] rom_page = 8'd0;
    logic [4:0] in_pins = 5'h1F;
    logic [5:0] reg_rdata, out_pins;
    logic       smi_req, clk_slow_req, clk_stop_req;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mfio_pins i_mfio_pins (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_out(alt_out),
        .rom_acc(rom_acc), .rom_page(rom_page), .in_pins(in_pins),
        .out_pins(out_pins), .smi_req(smi_req), .clk_slow_req(clk_slow_req),
        .clk_stop_req(clk_stop_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [5:0] m_osel, m_oval;
    logic [1:0] m_evsel, m_trig, m_pend;
    logic [3:0] m_en;
    logic       m_wp;
    logic [4:0] hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_osel = 6'h3B; m_oval = 6'h3F; m_evsel = 0; m_trig = 0;
            m_en = 0; m_pend = 0; m_wp = 1;
            hist = {5'h1F, 5'h1F, 5'h1F};
        end else begin
            logic [1:0] setv, clrv;
            setv = 0; clrv = 0;
            for (int e = 0; e < 2; e++)
                if (m_evsel[e] && m_trig[e] && hist[2][e] && !hist[1][e]) setv[e] = 1;
            if (reg_wr && reg_addr == 5) clrv = reg_wdata[1:0];
            m_pend = setv | (m_pend & ~clrv);
            if (rom_acc && rom_page == 8'h0F) m_wp = 0;
            else if (reg_wr && reg_addr == 0) m_wp = 1;
            if (reg_wr) begin
                case (reg_addr)
                    0: m_osel = reg_wdata;
                    1: m_oval = reg_wdata;
                    2: m_evsel = reg_wdata[1:0];
                    3: m_trig = reg_wdata[1:0];
                    4: m_en = reg_wdata[3:0];
                    default: ;
                endcase
            end
            hist.push_front(in_pins);
            void'(hist.pop_back());
        end
    end

    function automatic logic m_req(int e);
        if (!m_evsel[e]) return 1'b0;
        return m_trig[e] ? m_pend[e] : !hist[1][e];
    endfunction

    function automatic logic m_pin(int i);
        if (m_osel[i]) return m_oval[i];
        if (i == 2) return m_wp;
        return (i < 2) ? alt_out[i] : alt_out[i-1];
    endfunction

    function automatic logic [5:0] m_rd();
        case (reg_addr)
            0: return m_osel;
            1: return m_oval;
            2: return {4'b0, m_evsel};
            3: return {4'b0, m_trig};
            4: return {2'b0, m_en};
            5: return {4'b0, m_pend};
            6: return {1'b0, hist[1]};
            default: return 6'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, at the falling edge
    always @(negedge clk) begin
        if (running && !rst) begin
            for (int i = 0; i < 6; i++)
                chk(i == 2 ? "R3 wp pin" : "R2 pin", {5'b0, out_pins[i]}, {5'b0, m_pin(i)});
            chk("R8 smi", {5'b0, smi_req},
                {5'b0, (m_req(0) && m_en[0]) || (m_req(1) && m_en[2])});
            chk("R9 slow", {5'b0, clk_slow_req}, {5'b0, m_req(0) && m_en[1]});
            chk("R9 stop", {5'b0, clk_stop_req}, {5'b0, m_req(1) && m_en[3]});
            chk(reg_addr == 6 ? "R4 read" : (reg_addr == 5 ? "R7 read" : "R10 read"),
                reg_rdata, m_rd());
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [2:0] a, logic [5:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [5:0] exp);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 0;
        running = 1;
        tick(1);
        // R1 reset state
        chk("R1 pins", out_pins, 6'h3F);
        rd_chk("R1 outsel", 0, 6'h3B);
        rd_chk("R1 outval", 1, 6'h3F);
        rd_chk("R1 evsel", 2, 6'h00);
        rd_chk("R1 enable", 4, 6'h00);
        rd_chk("R1 pend", 5, 6'h00);
        // R2 select and level
        wr(1, 6'h15);
        chk("R2 gpo levels", out_pins, 6'h15 & 6'h3B | 6'h04);
        alt_out = 5'b00100; wr(0, 6'h00);
        chk("R2 alt mapping", out_pins, 6'b001000 | 6'h04);
        // R3 write-protect
        rom_page = 8'h0E; rom_acc = 1; tick(1);
        chk("R3 other page", {5'b0, out_pins[2]}, 6'd1);
        rom_page = 8'h0F; tick(1); rom_acc = 0;
        chk("R3 drop", {5'b0, out_pins[2]}, 6'd0);
        tick(5);
        chk("R3 stay low", {5'b0, out_pins[2]}, 6'd0);
        wr(0, 6'h00);
        chk("R3 rearm", {5'b0, out_pins[2]}, 6'd1);
        // R5 unselected pin stays quiet
        wr(4, 6'hF); in_pins[0] = 0; tick(4);
        chk("R5 no smi", {5'b0, smi_req}, 6'd0);
        rd_chk("R4 input read", 6, 6'h1E);
        in_pins[0] = 1; tick(3);
        // R6 level mode, two edges
        wr(2, 6'h3);
        in_pins[1] = 0; tick(1);
        chk("R6 after 1 edge", {5'b0, clk_stop_req}, 6'd0);
        tick(1);
        chk("R6 after 2 edges", {5'b0, clk_stop_req}, 6'd1);
        chk("R8 level smi", {5'b0, smi_req}, 6'd1);
        in_pins[1] = 1; tick(2);
        chk("R9 restart", {5'b0, clk_stop_req}, 6'd0);
        // R7 edge mode, three edges
        wr(3, 6'h1);
        in_pins[0] = 0; tick(2);
        chk("R7 after 2 edges", {5'b0, clk_slow_req}, 6'd0);
        tick(1);
        chk("R7 after 3 edges", {5'b0, clk_slow_req}, 6'd1);
        in_pins[0] = 1; tick(3);
        chk("R7 held", {5'b0, clk_slow_req}, 6'd1);
        wr(5, 6'h1);
        chk("R7 cleared", {5'b0, clk_slow_req}, 6'd0);
        // R10 read-only and unused addresses
        wr(6, 6'h3F); wr(7, 6'h3F);
        rd_chk("R10 addr7", 7, 6'h00);
        // Mixed random stimulus, model compared every clock
        for (int n = 0; n < 4000; n++) begin
            tick(1);
            for (int b = 0; b < 5; b++)
                if ($urandom_range(0, 5) == 0) in_pins[b] = ~in_pins[b];
            alt_out = 5'($urandom);
            rom_acc = ($urandom_range(0, 40) == 0);
            rom_page = $urandom_range(0, 1) ? 8'h0F : 8'($urandom);
            reg_wr = ($urandom_range(0, 6) == 0);
            reg_addr = 3'($urandom);
            reg_wdata = 6'($urandom);
        end
        tick(1);
        reg_wr = 0; rom_acc = 0;
        tick(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule